// File: doc/BRIEF.md
# Masked IR Message Match Filter

This block sits behind an infrared symbol decoder. Each time the decoder completes a message it strobes a valid signal with a 64-bit word. The block compares that word with a programmable pattern under a programmable mask. It keeps a small set of sticky interrupt flags and drives one registered interrupt line to the host. One message can raise a plain data-valid flag, a filtered match flag, or both. Each flag has its own enable bit. A mask of all zeros turns filtering off, so the host then takes every message through the data-valid flag.

The host reaches the block through a simple register port, with single-cycle writes and registered reads. A second decoder's valid strobe and an input-edge event are also recorded as flags. A wake input restricts the interrupt line to the match flag alone, so that while the system sleeps only a message that passes the filter can wake it.

Top module: `ir_msg_filter`

## Requirements
- R1: After reset every register reads zero, no flag is pending, and `irq` is low.
- R2: The pattern sits at address 0 (lower 32 bits) and address 1 (upper 32 bits). The mask sits at address 2 (lower) and address 3 (upper). The enable register is at address 4. Each of these reads back the value last written.
- R3: A message whose bits equal the pattern on every set mask bit sets the match flag, which is status bit 2. The status is read at address 6.
- R4: A message that differs from the pattern on any set mask bit leaves the match flag clear. Differences on bits where the mask is zero are ignored.
- R5: While both mask halves are zero, no message sets the match flag.
- R6: Every message strobe sets the data-valid flag (bit 0). The second-decoder strobe sets bit 1, and the edge event sets bit 3.
- R7: Writing to address 5 clears exactly the flags whose bits are one in the written value. Every other flag stays set until it is cleared.
- R8: When a clear write and a new event for the same flag fall in the same cycle, the flag ends up set.
- R9: `irq` goes high one clock after some flag is both pending and enabled in the enable register (bits as in R3 and R6). Removing an enable lowers `irq` but does not clear the flag.
- R10: While `wake_mode` is high, only the match flag can raise `irq`, whatever the enable register holds.
- R11: A pattern or mask write in the same cycle as a message strobe does not affect that message. The compare uses the values that were held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, one clock after `rd_addr` |
| msg_valid | input | 1 | Primary decoder message complete |
| msg_data | input | 64 | Decoded message word |
| msg2_valid | input | 1 | Second decoder message complete |
| edge_evt | input | 1 | Input edge detected |
| wake_mode | input | 1 | Restrict the interrupt to the match flag |
| irq | output | 1 | Registered interrupt line |

## Verification
Two things can land on the same flag register in one cycle: a host clear write and a newly arriving event. A filter register write and the message compare can also coincide. The bench drives a clear of the data-valid flag in the same clock as a message strobe, then reads the status to confirm the flag survived. It also rewrites the pattern in the same clock as a matching message, then checks that the match flag came from the old pattern and that the next message sees the new one.

// File: rtl/ir_filt_pkg.sv
package ir_filt_pkg;
  localparam int NSRC       = 4;
  localparam int SRC_VALID  = 0;
  localparam int SRC_VALID2 = 1;
  localparam int SRC_MATCH  = 2;
  localparam int SRC_EDGE   = 3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/ir_filt_regs.sv
module ir_filt_regs
  import ir_filt_pkg::*;
#(
  parameter int MSG_W  = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_vec_t          status,
  output logic [MSG_W-1:0]  pat_flat,
  output logic [MSG_W-1:0]  msk_flat,
  output src_vec_t          en_vec,
  output src_vec_t          clr_vec,
  output logic [REG_W-1:0]  rd_data
);
  localparam int LANES    = MSG_W / REG_W;
  localparam int A_EN     = 2 * LANES;
  localparam int A_CLR    = 2 * LANES + 1;
  localparam int A_STAT   = 2 * LANES + 2;

  logic [REG_W-1:0] pat_q [LANES];
  logic [REG_W-1:0] msk_q [LANES];
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] rd_q;
  logic [REG_W-1:0] rd_mux;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        pat_q[i] <= '0;
        msk_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(i))         pat_q[i] <= wr_data;
        if (wr_addr == ADDR_W'(LANES + i)) msk_q[i] <= wr_data;
      end
    end
    assign pat_flat[i*REG_W +: REG_W] = pat_q[i];
    assign msk_flat[i*REG_W +: REG_W] = msk_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                                  en_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(A_EN)) en_q <= wr_data;
  end

  assign en_vec  = en_q[NSRC-1:0];
  assign clr_vec = (wr_en && wr_addr == ADDR_W'(A_CLR)) ? wr_data[NSRC-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_addr == ADDR_W'(i))         rd_mux = pat_q[i];
      if (rd_addr == ADDR_W'(LANES + i)) rd_mux = msk_q[i];
    end
    if (rd_addr == ADDR_W'(A_EN))   rd_mux = en_q;
    if (rd_addr == ADDR_W'(A_STAT)) rd_mux = REG_W'(status);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/ir_filt_cmp.sv
module ir_filt_cmp #(
  parameter int MSG_W = 64,
  parameter int REG_W = 32
) (
  input  logic             msg_valid,
  input  logic [MSG_W-1:0] msg_data,
  input  logic [MSG_W-1:0] pat_flat,
  input  logic [MSG_W-1:0] msk_flat,
  output logic             match_evt
);
  localparam int LANES = MSG_W / REG_W;

  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] lane_armed;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    logic [REG_W-1:0] diff;
    assign diff          = (msg_data[i*REG_W +: REG_W] ^ pat_flat[i*REG_W +: REG_W])
                           & msk_flat[i*REG_W +: REG_W];
    assign lane_hit[i]   = (diff == '0);
    assign lane_armed[i] = |msk_flat[i*REG_W +: REG_W];
  end

  assign match_evt = msg_valid && (&lane_hit) && (|lane_armed);
endmodule

// File: rtl/ir_filt_irq.sv
module ir_filt_irq
  import ir_filt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t evt,
  input  src_vec_t clr,
  input  src_vec_t en,
  input  logic     wake_mode,
  output src_vec_t status,
  output logic     irq
);
  src_vec_t status_q;
  src_vec_t eff_en;
  logic     irq_q;

  always_comb begin
    eff_en = en;
    if (wake_mode) begin
      eff_en            = '0;
      eff_en[SRC_MATCH] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | evt;
      irq_q    <= |(status_q & eff_en);
    end
  end

  assign status = status_q;
  assign irq    = irq_q;
endmodule

// File: rtl/ir_msg_filter.sv
module ir_msg_filter
  import ir_filt_pkg::*;
#(
  parameter int MSG_W  = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = $clog2(2 * (MSG_W / REG_W) + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              msg_valid,
  input  logic [MSG_W-1:0]  msg_data,
  input  logic              msg2_valid,
  input  logic              edge_evt,
  input  logic              wake_mode,
  output logic              irq
);
  logic [MSG_W-1:0] pat_flat;
  logic [MSG_W-1:0] mask_flat;
  src_vec_t         en_vec;
  src_vec_t         clr_vec;
  src_vec_t         status_q;
  src_vec_t         evt_vec;
  logic             match_evt;

  ir_filt_regs #(.MSG_W(MSG_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status(status_q), .pat_flat(pat_flat), .msk_flat(mask_flat),
    .en_vec(en_vec), .clr_vec(clr_vec), .rd_data(rd_data)
  );

  ir_filt_cmp #(.MSG_W(MSG_W), .REG_W(REG_W)) u_cmp (
    .msg_valid(msg_valid), .msg_data(msg_data), .pat_flat(pat_flat),
    .msk_flat(mask_flat), .match_evt(match_evt)
  );

  always_comb begin
    evt_vec             = '0;
    evt_vec[SRC_VALID]  = msg_valid;
    evt_vec[SRC_VALID2] = msg2_valid;
    evt_vec[SRC_MATCH]  = match_evt;
    evt_vec[SRC_EDGE]   = edge_evt;
  end

  ir_filt_irq u_irq (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(clr_vec), .en(en_vec),
    .wake_mode(wake_mode), .status(status_q), .irq(irq)
  );
endmodule

// File: rtl/ir_msg_filter_chk.sv
module ir_msg_filter_chk
  import ir_filt_pkg::*;
#(
  parameter int MSG_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             wake_mode,
  input logic             irq,
  input logic [MSG_W-1:0] mask,
  input src_vec_t         status,
  input src_vec_t         en,
  input src_vec_t         clr
);
  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> status[SRC_VALID]); // R8

  AST_ZERO_MASK_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && mask == '0 && !status[SRC_MATCH]) |=> !status[SRC_MATCH]); // R5

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (!wake_mode && (status & en) != '0) |=> irq); // R9

  AST_WAKE_ONLY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (wake_mode && !status[SRC_MATCH]) |=> !irq); // R10
endmodule

bind ir_msg_filter ir_msg_filter_chk #(.MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .wake_mode(wake_mode), .irq(irq),
  .mask(mask_flat), .status(status_q), .en(en_vec), .clr(clr_vec)
);

// File: tb/sim_ir_msg_filter.sv
`timescale 1ns/1ps
module sim_ir_msg_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_data = '0;
  logic        msg2_valid = 1'b0;
  logic        edge_evt = 1'b0;
  logic        wake_mode = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ir_msg_filter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg2_valid(msg2_valid), .edge_evt(edge_evt), .wake_mode(wake_mode), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic msg(input logic [63:0] d);
    @(negedge clk); msg_valid = 1'b1; msg_data = d;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic irq_after(input string req, input logic exp);
    @(negedge clk);
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(3'd0, 32'hDEAD_0001); wr(3'd1, 32'hBEEF_0002);
    wr(3'd2, 32'h0F0F_0003); wr(3'd3, 32'hF0F0_0004); wr(3'd4, 32'h0000_000A);
    rd(3'd0, v); chk("R2 pat lo", v, 32'hDEAD_0001);
    rd(3'd1, v); chk("R2 pat hi", v, 32'hBEEF_0002);
    rd(3'd2, v); chk("R2 mask lo", v, 32'h0F0F_0003);
    rd(3'd3, v); chk("R2 mask hi", v, 32'hF0F0_0004);
    rd(3'd4, v); chk("R2 enable", v, 32'h0000_000A);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(3'd0, 32'h9ABC_DEF0); wr(3'd1, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h4);
    msg(64'h1234_5678_9ABC_DEF0);
    irq_after("R3 irq on match", 1'b1);
    rd(3'd6, v); chk("R3 match status", v, 32'h5);
    wr(3'd5, 32'h5);
    rd(3'd6, v); chk("R7 cleared", v, 32'h0);
    irq_after("R9 irq drops after clear", 1'b0);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    wr(3'd3, 32'h0);
    msg(64'hAAAA_5555_9ABC_DEF0);
    rd(3'd6, v); chk("R4 unmasked bits ignored", v, 32'h5);
    wr(3'd5, 32'hF);
    msg(64'h1234_5678_9ABC_DEF1);
    rd(3'd6, v); chk("R4 masked mismatch", v, 32'h1);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_zero_mask;
    logic [31:0] v;
    wr(3'd2, 32'h0);
    msg(64'h1234_5678_9ABC_DEF0);
    rd(3'd6, v); chk("R5 zero mask no match", v, 32'h1);
    chk("R5 irq low with match enable", {31'b0, irq}, 32'h0);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_sources;
    logic [31:0] v;
    @(negedge clk); msg2_valid = 1'b1;
    @(negedge clk); msg2_valid = 1'b0; edge_evt = 1'b1;
    @(negedge clk); edge_evt = 1'b0;
    rd(3'd6, v); chk("R6 second valid and edge", v, 32'hA);
    wr(3'd5, 32'h2);
    rd(3'd6, v); chk("R7 partial clear", v, 32'h8);
  endtask

  task automatic t_enable_drop;
    logic [31:0] v;
    wr(3'd4, 32'h8);
    irq_after("R9 irq from edge flag", 1'b1);
    wr(3'd4, 32'h0);
    irq_after("R9 irq off when disabled", 1'b0);
    rd(3'd6, v); chk("R9 flag kept", v, 32'h8);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    msg(64'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h1; msg_valid = 1'b1; msg_data = 64'h0;
    @(negedge clk); wr_en = 1'b0; msg_valid = 1'b0;
    rd(3'd6, v); chk("R8 event beats clear", v, 32'h1);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_wake;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd4, 32'hF);
    @(negedge clk); wake_mode = 1'b1; msg2_valid = 1'b1; edge_evt = 1'b1;
    @(negedge clk); msg2_valid = 1'b0; edge_evt = 1'b0;
    msg(64'h0);
    irq_after("R10 non-match blocked in wake", 1'b0);
    msg(64'h1234_5678_9ABC_DEF0);
    irq_after("R10 match wakes", 1'b1);
    rd(3'd6, v); chk("R10 status", v, 32'hF);
    @(negedge clk); wake_mode = 1'b0;
    wr(3'd5, 32'hF);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_update;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0000_0001;
    msg_valid = 1'b1; msg_data = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk); wr_en = 1'b0; msg_valid = 1'b0;
    rd(3'd6, v); chk("R11 old pattern used", v, 32'h5);
    wr(3'd5, 32'hF);
    msg(64'h1234_5678_9ABC_DEF0);
    rd(3'd6, v); chk("R11 new pattern next msg", v, 32'h1);
    msg(64'h1234_5678_0000_0001);
    rd(3'd6, v); chk("R11 new pattern matches", v, 32'h5);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_match();
    t_mismatch();
    t_zero_mask();
    t_sources();
    t_enable_drop();
    t_collide();
    t_wake();
    t_update();
    finish_run();
  end
endmodule